// File: doc/BRIEF.md
# Interrupt Pin Redirection Controller

This block turns a set of external interrupt pins into interrupt messages addressed to processors. Software programs one routing entry per pin. The entry sets the vector, the delivery kind, how the destination is interpreted, the destination itself, the active level, edge or level detection, and a mask. The block samples the pins and applies each pin's polarity and trigger setting. It then emits one message at a time on a valid/ready output carrying the vector, delivery kind, destination mode and destination.

Software reaches every internal register indirectly, through two 32-bit bus registers. An index register at offset 0x00 selects an internal register, and a window at offset 0x10 reads or writes the selected one. Level-triggered pins use an acknowledge flag. The flag is set once a message from that pin has been accepted, and an end-of-interrupt carrying the same vector clears it. While the flag is set, the pin stays silent even if its input is still active.

Top module: `irq_router`

## Requirements
- R1: A bus write to offset 0x00 stores bits 7:0 of the data as the index register. A read at 0x00 returns that index with the upper bits zero. Offset 0x10 reads or writes the indexed register. Any other offset reads zero. Read data appears registered, one clock after the read strobe.
- R2: Index 0x00 is the identifier register. Bits 27:24 can be written and read back, and all other bits read 0.
- R3: Index 0x01 reads a constant version word of 0x00000011 and ignores writes.
- R4: Entry n occupies index 0x10+2n (low half) and index 0x11+2n (high half). The high half holds the destination in bits 31:24, and its other bits read 0.
- R5: After reset, every entry's low half reads 0x00010000, which is the mask set and everything else zero. Every high half reads 0, the identifier reads 0, and no message is valid.
- R6: The low-half layout is: vector [7:0], delivery kind [10:8], destination mode [11], delivery status [12], polarity [13] (0 means active high, 1 means active low), acknowledge flag [14], trigger [15] (0 means edge, 1 means level), and mask [16]. An unmasked edge entry emits exactly one message for each inactive-to-active transition of its pin.
- R7: A masked pin emits no message. An edge that arrives while the pin is masked is discarded and is not delivered after a later unmask.
- R8: An unmasked level entry whose pin is active emits one message. After acceptance its acknowledge flag reads 1, and it emits no further message until an end-of-interrupt with its vector clears the flag. If the pin is still active at that point, it then emits again.
- R9: An end-of-interrupt whose vector differs from the entry's vector leaves the acknowledge flag set.
- R10: A message carries the entry's vector, delivery kind, destination mode and destination. While ready is low, the message stays valid and unchanged.
- R11: Software writes to bits 12 and 14 have no effect. Bit 12 reads 1 while the pin has a request that has not yet been accepted.
- R12: When several pins request at once, the lowest-numbered pin is delivered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Bus byte offset (0x00 index, 0x10 window) |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| irq_in | input | NPINS | External interrupt pins |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector being retired |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Delivery path can take the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery kind |
| msg_dest_mode | output | 1 | Message destination mode |
| msg_dest | output | 8 | Message destination |

## Verification
A wrong edge latch or a stale acknowledge flag shows up at the ports within a few cycles. It appears either as an extra message on the output or as a message that never comes, and the scoreboard flags both. A corrupted routing entry shows up at the next message from that pin as a wrong vector or destination. A read of the entry's low half exposes the same fault, along with the status and acknowledge bits, one cycle after the read strobe. A broken hold under back-pressure shows as a changed vector while ready is low.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dmode;
    logic [2:0] dlv;
    logic [7:0] vec;
  } rte_t;

  localparam logic [7:0] OFS_INDEX  = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] IDX_ID     = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_TABLE  = 8'h10;
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] trig,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] rirr,
  input  logic [NPINS-1:0] take,
  output logic [NPINS-1:0] req
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic s1, s2, epend;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1    <= 1'b0;
        s2    <= 1'b0;
        epend <= 1'b0;
      end else begin
        s1 <= pins[g] ^ pol[g];
        s2 <= s1;
        if (!trig[g] && !mask[g] && s1 && !s2) epend <= 1'b1;
        else if (take[g])                      epend <= 1'b0;
      end
    end
    assign req[g] = !mask[g] && (trig[g] ? (s1 && !rirr[g]) : epend);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NPINS = 8,
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [NPINS-1:0] req,
  input  logic [NPINS-1:0] excl,
  output logic             any,
  output logic [IW-1:0]    idx
);
  logic [NPINS-1:0] cand;
  assign cand = req & ~excl;
  assign any  = |cand;

  always_comb begin
    idx = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int         NPINS   = 8,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] irq_in,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vec,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [7:0]       msg_vector,
  output logic [2:0]       msg_mode,
  output logic             msg_dest_mode,
  output logic [7:0]       msg_dest
);
  localparam int         IW    = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [8:0] TBL_END = 9'(16 + 2 * NPINS);

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  rte_t             tbl [NPINS];
  logic [NPINS-1:0] rirr, req, take, excl;
  logic [NPINS-1:0] pol_v, trig_v, mask_v;
  logic [IW-1:0]    cur_idx, pick_idx, ent_idx;
  logic [7:0]       ent_off;
  logic             ent_hit, ent_hi, win_wr, pick_any, load, accept;
  logic [31:0]      win_data;
  logic             unused_ok;

  assign unused_ok = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

  // Bus decode
  assign win_wr  = bus_wr && (bus_addr == OFS_WINDOW);
  assign ent_off = sel_q - IDX_TABLE;
  assign ent_hit = (sel_q >= IDX_TABLE) && ({1'b0, sel_q} < TBL_END);
  assign ent_hi  = sel_q[0];
  assign ent_idx = IW'(ent_off[7:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_INDEX) sel_q <= bus_wdata[7:0];
      if (win_wr && sel_q == IDX_ID)       id_q  <= bus_wdata[27:24];
    end
  end

  // Routing table and acknowledge flags
  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[g]      <= '0;
        tbl[g].mask <= 1'b1;
      end else if (win_wr && ent_hit && ent_idx == IW'(g)) begin
        if (ent_hi) tbl[g].dest <= bus_wdata[31:24];
        else begin
          tbl[g].vec   <= bus_wdata[7:0];
          tbl[g].dlv   <= bus_wdata[10:8];
          tbl[g].dmode <= bus_wdata[11];
          tbl[g].pol   <= bus_wdata[13];
          tbl[g].trig  <= bus_wdata[15];
          tbl[g].mask  <= bus_wdata[16];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                                         rirr[g] <= 1'b0;
      else if (accept && cur_idx == IW'(g) && tbl[g].trig) rirr[g] <= 1'b1;
      else if (eoi_valid && eoi_vec == tbl[g].vec)      rirr[g] <= 1'b0;
      else if (!tbl[g].trig)                            rirr[g] <= 1'b0;
    end

    assign pol_v[g]  = tbl[g].pol;
    assign trig_v[g] = tbl[g].trig;
    assign mask_v[g] = tbl[g].mask;

    // R7: a masked entry never raises a request
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (rst)
      tbl[g].mask |-> !req[g]);
    // R8: an acknowledged level entry stays silent until end-of-interrupt
    a_r8_ack_blocks: assert property (@(posedge clk) disable iff (rst)
      (rirr[g] && tbl[g].trig) |-> !req[g]);
  end

  irq_pin_detect #(.NPINS(NPINS)) det_i (
    .clk(clk), .rst(rst), .pins(irq_in), .pol(pol_v), .trig(trig_v),
    .mask(mask_v), .rirr(rirr), .take(take), .req(req)
  );

  // Message output
  assign accept = msg_valid && msg_ready;
  assign excl   = msg_valid ? (NPINS'(1) << cur_idx) : '0;
  assign take   = accept ? (NPINS'(1) << cur_idx) : '0;
  assign load   = pick_any && (!msg_valid || msg_ready);

  irq_pick #(.NPINS(NPINS)) pick_i (
    .req(req), .excl(excl), .any(pick_any), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid     <= 1'b0;
      msg_vector    <= '0;
      msg_mode      <= '0;
      msg_dest_mode <= 1'b0;
      msg_dest      <= '0;
      cur_idx       <= '0;
    end else if (load) begin
      msg_valid     <= 1'b1;
      msg_vector    <= tbl[pick_idx].vec;
      msg_mode      <= tbl[pick_idx].dlv;
      msg_dest_mode <= tbl[pick_idx].dmode;
      msg_dest      <= tbl[pick_idx].dest;
      cur_idx       <= pick_idx;
    end else if (accept) begin
      msg_valid <= 1'b0;
    end
  end

  // R10: back-pressure holds the message unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)));
  // R5: no message in the first cycle after reset
  a_r5_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !msg_valid);

  // Register window read
  always_comb begin
    win_data = '0;
    if (sel_q == IDX_ID)       win_data = {4'b0, id_q, 24'b0};
    else if (sel_q == IDX_VER) win_data = {24'b0, VERSION};
    else if (ent_hit) begin
      if (ent_hi) win_data = {tbl[ent_idx].dest, 24'b0};
      else win_data = {15'b0, tbl[ent_idx].mask, tbl[ent_idx].trig, rirr[ent_idx],
                       tbl[ent_idx].pol, req[ent_idx], tbl[ent_idx].dmode,
                       tbl[ent_idx].dlv, tbl[ent_idx].vec};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        OFS_INDEX:  bus_rdata <= {24'b0, sel_q};
        OFS_WINDOW: bus_rdata <= win_data;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
  localparam int NPINS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NPINS-1:0] irq_in = '0;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vec = '0;
  logic msg_valid, msg_ready = 1'b1, msg_dest_mode;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_mode;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [19:0] exp_q[$];

  always #2 clk = ~clk;

  irq_router #(.NPINS(NPINS)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_dest_mode(msg_dest_mode), .msg_dest(msg_dest)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [31:0] d);
    bus_write(8'h00, {24'b0, idx});
    bus_write(8'h10, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [31:0] d);
    bus_write(8'h00, {24'b0, idx});
    bus_read(8'h10, d);
  endtask

  task automatic expect_msg(input logic [7:0] v, input logic [2:0] m,
                            input logic dm, input logic [7:0] dst);
    exp_q.push_back({v, m, dm, dst});
  endtask

  task automatic pulse(input int pin, input logic level);
    @(negedge clk); irq_in[pin] = level;
    repeat (2) @(negedge clk);
    irq_in[pin] = ~level;
  endtask

  task automatic drain(input string req);
    repeat (12) @(negedge clk);
    check(32'(exp_q.size()), 32'd0, req);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 R8: actual=unexpected message vec %h expected=no message", msg_vector);
      end else begin
        logic [19:0] e;
        e = exp_q.pop_front();
        if ({msg_vector, msg_mode, msg_dest_mode, msg_dest} !== e) begin
          errors++;
          $display("FAIL R10: actual=%h expected=%h",
                   {msg_vector, msg_mode, msg_dest_mode, msg_dest}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R5 reset state
    check({31'b0, msg_valid}, 32'd0, "R5");
    reg_rd(8'h10, d); check(d, 32'h0001_0000, "R5");
    reg_rd(8'h1F, d); check(d, 32'h0, "R5");
    reg_rd(8'h00, d); check(d, 32'h0, "R5");

    // R1 index register and unused offsets
    bus_write(8'h00, 32'hFFFF_FF5A);
    bus_read(8'h00, d); check(d, 32'h0000_005A, "R1");
    bus_read(8'h04, d); check(d, 32'h0, "R1");

    // R2 identifier, R3 version
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, d); check(d, 32'h0F00_0000, "R2");
    reg_wr(8'h01, 32'h0);
    reg_rd(8'h01, d); check(d, 32'h0000_0011, "R3");

    // R4 high half holds only the destination
    reg_wr(8'h1F, 32'hFFFF_FFFF);
    reg_rd(8'h1F, d); check(d, 32'hFF00_0000, "R4");

    // R6 R11 edge entry on pin 2, status/ack bits not writable
    reg_wr(8'h15, 32'h0500_0000);
    reg_wr(8'h14, 32'h0000_5041);
    reg_rd(8'h14, d); check(d, 32'h0000_0041, "R11");
    expect_msg(8'h41, 3'd0, 1'b0, 8'h05);
    pulse(2, 1'b1);
    drain("R6");

    // R7 masked edge discarded, also after unmask
    reg_wr(8'h16, 32'h0001_0033);
    pulse(3, 1'b1);
    reg_wr(8'h16, 32'h0000_0033);
    drain("R7");

    // R6 active-low edge on pin 4
    irq_in[4] = 1'b1;
    reg_wr(8'h19, 32'h0400_0000);
    reg_wr(8'h18, 32'h0000_2044);
    drain("R6");
    expect_msg(8'h44, 3'd0, 1'b0, 8'h04);
    pulse(4, 1'b0);
    drain("R6");

    // R8 R9 level entry on pin 5 with acknowledge
    reg_wr(8'h1B, 32'h0900_0000);
    expect_msg(8'h63, 3'd1, 1'b0, 8'h09);
    reg_wr(8'h1A, 32'h0000_8163);
    @(negedge clk); irq_in[5] = 1'b1;
    drain("R8");
    reg_rd(8'h1A, d); check(d, 32'h0000_C163, "R8");
    @(negedge clk); eoi_vec = 8'h64; eoi_valid = 1'b1;
    @(negedge clk); eoi_valid = 1'b0;
    drain("R9");
    reg_rd(8'h1A, d); check(d, 32'h0000_C163, "R9");
    expect_msg(8'h63, 3'd1, 1'b0, 8'h09);
    @(negedge clk); eoi_vec = 8'h63; eoi_valid = 1'b1;
    @(negedge clk); eoi_valid = 1'b0;
    drain("R8");
    @(negedge clk); irq_in[5] = 1'b0;
    repeat (3) @(negedge clk);
    eoi_valid = 1'b1;
    @(negedge clk); eoi_valid = 1'b0;
    drain("R8");
    reg_rd(8'h1A, d); check(d, 32'h0000_8163, "R8");

    // R10 R11 R12 back-pressure with two simultaneous requests
    reg_wr(8'h1D, 32'h2200_0000);
    reg_wr(8'h1C, 32'h0000_0C70);
    reg_wr(8'h13, 32'h0100_0000);
    reg_wr(8'h12, 32'h0000_0030);
    @(negedge clk); msg_ready = 1'b0;
    expect_msg(8'h30, 3'd0, 1'b0, 8'h01);
    expect_msg(8'h70, 3'd4, 1'b1, 8'h22);
    irq_in[1] = 1'b1; irq_in[6] = 1'b1;
    repeat (2) @(negedge clk);
    irq_in[1] = 1'b0; irq_in[6] = 1'b0;
    repeat (4) @(negedge clk);
    check({31'b0, msg_valid}, 32'd1, "R10");
    check({24'b0, msg_vector}, 32'h30, "R12");
    reg_rd(8'h1C, d); check(d, 32'h0000_1C70, "R11");
    check({24'b0, msg_vector}, 32'h30, "R10");
    @(negedge clk); msg_ready = 1'b1;
    drain("R12");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule